// File: doc/BRIEF.md
# Dual-Mode 24-Clock Serial Register Slave

This block is a serial slave that reads and writes a 128-entry space of 16-bit registers. A host drives SCLK, SDI and an active-low chip select. The block answers on SDO, with a separate output-enable so SDO can float when not in use. Every access is a fixed 24-clock frame. The frame carries an access-type bit, a 7-bit register index and a 16-bit data word. The block runs on a system clock much faster than SCLK and samples all three host lines in that clock domain.

Two framing styles are supported and chosen by a static mode input. In four-wire mode, chip select brackets each frame. In three-wire mode, chip select is not used, SCLK idles high, and a new frame begins once SCLK has stayed low for a programmable number of system cycles. Either mode aborts a frame when SCLK stops toggling for too long. A frame with too many clocks, or a register index that no register claims, has a defined outcome. The register storage sits outside the block and connects through a plain address/strobe/data port. That port reports through `reg_hit` whether the current index is implemented.

Top module: `spi24_reg_slave`

## Requirements
- R1: A frame carries, MSB first in this order, one access bit (1 = read, 0 = write), a 7-bit register index and 16 data bits, sampled from SDI on rising SCLK edges; a full frame is exactly 24 rising edges.
- R2: In a read frame, `sdo` presents data bit 15 after the falling SCLK edge that follows the 8th rising edge, then one lower bit per falling edge; `sdo_oe` is 1 only in that data phase and drops at the falling edge after the 24th rising edge or at frame end; `sdo_oe` stays 0 through write frames.
- R3: With `mode_3w` = 0, a frame opens on a falling `cs_n` and closes on a rising `cs_n`; SCLK activity while `cs_n` is high has no effect.
- R4: With `mode_3w` = 1, `cs_n` is ignored, and a frame opens once SCLK has been low for START_LOW_CYC system cycles; that same event closes any frame still open.
- R5: If SCLK shows no edge for TIMEOUT_CYC system cycles while a frame is open, the frame ends; in four-wire mode a pending write is dropped, and in three-wire mode it is committed when exactly 24 clocks were seen.
- R6: A frame with more than 24 rising edges performs no write; a read in such a frame still returns its data on the first 24 clocks, and `sdo_oe` stays 0 for the extra clocks.
- R7: A write commits as a single-cycle `reg_wr_en` pulse carrying `reg_addr` and `reg_wdata`. It happens only when a write frame with exactly 24 rising edges is closed (rising `cs_n` in four-wire mode, the next frame start or a timeout in three-wire mode). Shorter frames write nothing.
- R8: When `reg_hit` is 0 for the frame's index, a read returns 0x0000 on SDO with no `reg_rd_en` pulse, and a write produces no `reg_wr_en` pulse.
- R9: `last_word` holds the most recent read word as sent on SDO, or the data of the most recent 24-clock write frame, whichever came later; it is 0 after reset.
- R10: During and right after reset, `sdo_oe`, `reg_wr_en` and `reg_rd_en` are 0 and `last_word` is 0.
- R11: Each read frame to an implemented index issues exactly one single-cycle `reg_rd_en` pulse, after the index has been received and before the first data bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_3w | input | 1 | 1 = three-wire framing, 0 = four-wire framing; held static |
| cs_n | input | 1 | Chip select from host, active low (four-wire mode only) |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| sdo_oe | output | 1 | Drive enable for `sdo`; 0 means high impedance |
| reg_addr | output | 7 | Register index of the current frame |
| reg_rd_en | output | 1 | Single-cycle read strobe to the register space |
| reg_rdata | input | 16 | Read data for `reg_addr`, combinational |
| reg_wr_en | output | 1 | Single-cycle write strobe to the register space |
| reg_wdata | output | 16 | Write data accompanying `reg_wr_en` |
| reg_hit | input | 1 | 1 when `reg_addr` names an implemented register |
| last_word | output | 16 | Last word read or written |

## Verification
On every cycle, the assertions check the following. The drive enable is never raised outside a read frame, and `sdo` moves only after a falling SCLK edge. Read and write strobes last one cycle. Chip select held high keeps the frame closed, an expired inactivity counter always closes the frame, and the bit counter stays saturated. The bench scenarios are the only check of the end-to-end results. These are the bit order and data seen on SDO and which frame lengths commit a write. They also cover the different timeout outcomes of the two modes, zero reads and dropped writes at unimplemented indices, and the three-wire frame start after a long SCLK-low period.

// File: rtl/spi24_pkg.sv
// Shared constants of the 24-clock serial register slave.
// Assumes a fixed frame of 1 access bit, 7 index bits and 16 data bits.
package spi24_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 16;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER     = CNT_W'(FRAME_BITS + 1);
endpackage

// File: rtl/spi24_sync.sv
// Two-flop level synchronizer for N asynchronous inputs.
// Assumes each input is stable for more than two system cycles between changes.
module spi24_sync #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    // Two-stage capture of the raw inputs into the system domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign lvl = sync_q;
endmodule

// File: rtl/spi24_edge.sv
// Rising/falling edge detector for N synchronized levels.
// Assumes inputs already belong to the system clock domain.
module spi24_edge #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    // Remember last cycle's level of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    // Per-bit edge decode.
    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = lvl[g] & ~prev_q[g];
        assign fall[g] = ~lvl[g] & prev_q[g];
    end
endmodule

// File: rtl/spi24_framer.sv
// Frame control: opens and closes frames in either framing mode, runs the
// inactivity timeout and counts rising SCLK edges (saturating above a full frame).
// Assumes mode_3w is static while frames are in flight.
module spi24_framer
    import spi24_pkg::*;
#(
    parameter int START_LOW_CYC = 3200,
    parameter int TIMEOUT_CYC   = 48000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_3w,
    input  logic             cs_lvl,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic             sclk_lvl,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    output logic             frame_act,
    output logic             frame_start,
    output logic             frame_close,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam int LOW_W = $clog2(START_LOW_CYC + 1);
    localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(START_LOW_CYC - 1);
    localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(START_LOW_CYC);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);
    localparam logic [TMO_W-1:0] TMO_SAT  = TMO_W'(TIMEOUT_CYC);

    logic [LOW_W-1:0] low_cnt;
    logic [TMO_W-1:0] idle_cnt;
    logic             start_3w;
    logic             sclk_edge;
    logic             tmo_hit;
    logic             frame_abort;

    assign sclk_edge   = sclk_rise | sclk_fall;
    assign start_3w    = mode_3w && !sclk_lvl && (low_cnt == LOW_LAST);
    assign tmo_hit     = frame_act && !sclk_edge && (idle_cnt == TMO_LAST);
    assign frame_start = mode_3w ? start_3w : cs_fall;
    assign frame_close = frame_act && (mode_3w ? (start_3w || tmo_hit) : cs_rise);
    assign frame_abort = frame_act && !mode_3w && tmo_hit && !cs_rise;

    // Measure how long SCLK has been low, saturating at the start threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || sclk_lvl)    low_cnt <= '0;
        else if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
    end

    // Count system cycles without an SCLK edge while a frame is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_act || sclk_edge || frame_start) idle_cnt <= '0;
        else if (idle_cnt != TMO_SAT)                         idle_cnt <= idle_cnt + 1'b1;
    end

    // Frame-open flag: a start wins over a close landing in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          frame_act <= 1'b0;
        else if (frame_start)                frame_act <= 1'b1;
        else if (frame_close || frame_abort) frame_act <= 1'b0;
    end

    // Rising-edge counter of the open frame, held once past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start)                             bit_cnt <= '0;
        else if (frame_act && sclk_rise && bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end

    assert_cs_high_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_3w && cs_lvl) |=> !frame_act);

    assert_timeout_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_act && idle_cnt == TMO_LAST && !sclk_edge && !frame_start) |=> !frame_act);

    assert_count_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_OVER && !frame_start) |=> bit_cnt == CNT_OVER);
endmodule

// File: rtl/spi24_shifter.sv
// Serial data path: shifts SDI in on rising edges, latches access bit and index
// after the header, and shifts read data out on falling edges with a drive enable.
// Assumes an SCLK half period of at least four system cycles.
module spi24_shifter
    import spi24_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_act,
    input  logic              frame_start,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_lvl,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_word,
    output logic              rw_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] rx_word,
    output logic              hdr_done,
    output logic              sdo_q,
    output logic              sdo_oe
);
    logic [DATA_W-1:0] tx_q;
    logic              take_bit;
    logic              hdr_last;
    logic              in_dphase;

    assign take_bit  = frame_act && sclk_rise && (bit_cnt < CNT_FULL);
    assign hdr_last  = frame_act && sclk_rise && (bit_cnt == CNT_HDR_LAST);
    assign in_dphase = rw_q && (bit_cnt >= CNT_HDR) && (bit_cnt < CNT_FULL);

    // Receive shift register; after a full frame it holds the data word.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_word <= '0;
        else if (take_bit) rx_word <= {rx_word[DATA_W-2:0], sdi_lvl};
    end

    // Latch access type and index on the last header bit.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            rw_q   <= 1'b0;
            addr_q <= '0;
        end else if (hdr_last) begin
            rw_q   <= rx_word[ADDR_W-1];
            addr_q <= {rx_word[ADDR_W-2:0], sdi_lvl};
        end
    end

    // One-cycle marker that the header is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) hdr_done <= 1'b0;
        else        hdr_done <= hdr_last;
    end

    // Transmit register: load read word, then emit MSB first on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            sdo_q <= 1'b0;
        end else if (load_en) begin
            tx_q <= load_word;
        end else if (frame_act && sclk_fall && in_dphase) begin
            sdo_q <= tx_q[DATA_W-1];
            tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    // Drive enable follows the read data phase, updated on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_act || frame_start) sdo_oe <= 1'b0;
        else if (sclk_fall)                      sdo_oe <= in_dphase;
    end

    assert_oe_only_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> rw_q);

    assert_sdo_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo_q));
endmodule

// File: rtl/spi24_reg_slave.sv
// Top of the 24-clock serial register slave. Synchronizes host lines, frames
// accesses in four- or three-wire mode, fetches read data after the header and
// commits writes only for exactly-24-clock frames to implemented indices.
// Assumes the register space answers reg_rdata and reg_hit combinationally.
module spi24_reg_slave
    import spi24_pkg::*;
#(
    parameter int START_LOW_CYC = 3200,
    parameter int TIMEOUT_CYC   = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_3w,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_hit,
    output logic [DATA_W-1:0] last_word
);
    logic [2:0]        in_lvl;
    logic [1:0]        ctl_rise;
    logic [1:0]        ctl_fall;
    logic              frame_act;
    logic              frame_start;
    logic              frame_close;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rw_q;
    logic              hdr_done;
    logic [DATA_W-1:0] rx_word;
    logic [DATA_W-1:0] read_word;
    logic              rd_fire;
    logic              commit;

    spi24_sync #(.N(3), .RST_VAL(3'b110)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, sdi}),
        .lvl   (in_lvl)
    );

    spi24_edge #(.N(2), .RST_VAL(2'b11)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (in_lvl[2:1]),
        .rise  (ctl_rise),
        .fall  (ctl_fall)
    );

    spi24_framer #(
        .START_LOW_CYC (START_LOW_CYC),
        .TIMEOUT_CYC   (TIMEOUT_CYC)
    ) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_3w     (mode_3w),
        .cs_lvl      (in_lvl[2]),
        .cs_rise     (ctl_rise[1]),
        .cs_fall     (ctl_fall[1]),
        .sclk_lvl    (in_lvl[1]),
        .sclk_rise   (ctl_rise[0]),
        .sclk_fall   (ctl_fall[0]),
        .frame_act   (frame_act),
        .frame_start (frame_start),
        .frame_close (frame_close),
        .bit_cnt     (bit_cnt)
    );

    spi24_shifter i_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_act   (frame_act),
        .frame_start (frame_start),
        .sclk_rise   (ctl_rise[0]),
        .sclk_fall   (ctl_fall[0]),
        .sdi_lvl     (in_lvl[0]),
        .bit_cnt     (bit_cnt),
        .load_en     (rd_fire),
        .load_word   (read_word),
        .rw_q        (rw_q),
        .addr_q      (reg_addr),
        .rx_word     (rx_word),
        .hdr_done    (hdr_done),
        .sdo_q       (sdo),
        .sdo_oe      (sdo_oe)
    );

    // Read fetch right after the header; unimplemented indices read as zero.
    assign rd_fire   = hdr_done && rw_q && frame_act;
    assign read_word = reg_hit ? reg_rdata : '0;
    assign reg_rd_en = rd_fire && reg_hit;

    // Write commit only when a write frame of exactly 24 clocks is closed.
    assign commit    = frame_close && !rw_q && (bit_cnt == CNT_FULL);
    assign reg_wr_en = commit && reg_hit;
    assign reg_wdata = rx_word;

    // Track the last word read out or written in.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_word <= '0;
        else if (rd_fire) last_word <= read_word;
        else if (commit)  last_word <= rx_word;
    end

    assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    assert_rd_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    assert_no_wr_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> !reg_wr_en);
endmodule

// File: tb/test_spi24_reg_slave.sv
module test_spi24_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int START_LOW  = 40;
    localparam int TMO        = 300;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_3w = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        sdo_oe;
    logic [6:0]  reg_addr;
    logic        reg_rd_en;
    logic [15:0] reg_rdata;
    logic        reg_wr_en;
    logic [15:0] reg_wdata;
    logic        reg_hit;
    logic [15:0] last_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mem [0:127];
    int wr_cnt = 0;
    int rd_cnt = 0;

    logic [15:0] rd_word;
    int oe_in;
    int oe_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi24_reg_slave #(.START_LOW_CYC(START_LOW), .TIMEOUT_CYC(TMO)) i_spi24_reg_slave (
        .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_rd_en(reg_rd_en),
        .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_hit(reg_hit), .last_word(last_word)
    );

    function automatic logic [15:0] init_val(input int a);
        return 16'((a * 16'h0101) ^ 16'h5A5A);
    endfunction

    // Bench register space: indices below 0x60 are implemented.
    assign reg_rdata = mem[reg_addr];
    assign reg_hit   = (reg_addr < 7'h60);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
            wr_cnt <= 0;
            rd_cnt <= 0;
        end else begin
            if (reg_wr_en) begin
                mem[reg_addr] <= reg_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (reg_rd_en) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks one frame; bits past 24 send zero. Collects SDO and drive-enable samples.
    task automatic clock_frame(input bit rw, input logic [6:0] a, input logic [15:0] d,
                               input int nclk, input bit first_low);
        logic [23:0] word;
        word = {rw, a, d};
        rd_word = '0;
        oe_in = 0;
        oe_out = 0;
        for (int i = 0; i < nclk; i++) begin
            if (!(first_low && i == 0)) sclk = 1'b0;
            sdi = (i < 24) ? word[23 - i] : 1'b0;
            wait_cyc(HALF);
            if (i >= 8 && i < 24) begin
                rd_word = {rd_word[14:0], sdo};
                if (sdo_oe) oe_in++;
            end else if (sdo_oe) begin
                oe_out++;
            end
            sclk = 1'b1;
            wait_cyc(HALF);
        end
    endtask

    task automatic four_wire(input bit rw, input logic [6:0] a, input logic [15:0] d, input int nclk);
        cs_n = 1'b0;
        wait_cyc(HALF);
        clock_frame(rw, a, d, nclk, 1'b0);
        wait_cyc(HALF);
        cs_n = 1'b1;
        wait_cyc(2 * HALF);
        if (sdo_oe) oe_out++;
    endtask

    task automatic three_wire(input bit rw, input logic [6:0] a, input logic [15:0] d, input int nclk);
        sclk = 1'b0;
        wait_cyc(START_LOW + 10);
        clock_frame(rw, a, d, nclk, 1'b1);
        wait_cyc(HALF);
    endtask

    task automatic t_reset;
        chk("R10 sdo_oe", sdo_oe, 0);
        chk("R10 last_word", last_word, 0);
        chk("R10 reg_wr_en", reg_wr_en, 0);
        chk("R10 reg_rd_en", reg_rd_en, 0);
    endtask

    task automatic t_write_read_4w;
        int w0;
        int r0;
        w0 = wr_cnt;
        four_wire(1'b0, 7'h12, 16'hBEEF, 24);
        chk("R7 write commits once", wr_cnt - w0, 1);
        chk("R2 no drive in write frame", oe_out, 0);
        r0 = rd_cnt;
        four_wire(1'b1, 7'h12, 16'h0000, 24);
        chk("R1 readback data", rd_word, 16'hBEEF);
        chk("R2 drive in data phase", oe_in, 16);
        chk("R2 no drive outside data phase", oe_out, 0);
        chk("R11 one read strobe", rd_cnt - r0, 1);
        chk("R9 last word after read", last_word, 16'hBEEF);
        four_wire(1'b1, 7'h21, 16'h0000, 24);
        chk("R1 initial value readback", rd_word, init_val(7'h21));
    endtask

    task automatic t_cs_high_4w;
        int w0;
        w0 = wr_cnt;
        clock_frame(1'b0, 7'h12, 16'h0000, 24, 1'b0);
        wait_cyc(4 * HALF);
        chk("R3 clocks with cs high ignored", wr_cnt - w0, 0);
        four_wire(1'b1, 7'h12, 16'h0000, 24);
        chk("R3 register untouched", rd_word, 16'hBEEF);
    endtask

    task automatic t_short_4w;
        int w0;
        w0 = wr_cnt;
        four_wire(1'b0, 7'h13, 16'h1111, 20);
        chk("R7 short frame no write", wr_cnt - w0, 0);
        four_wire(1'b1, 7'h13, 16'h0000, 24);
        chk("R7 short frame register kept", rd_word, init_val(7'h13));
    endtask

    task automatic t_over_4w;
        int w0;
        w0 = wr_cnt;
        four_wire(1'b0, 7'h14, 16'h2222, 25);
        chk("R6 long write dropped", wr_cnt - w0, 0);
        four_wire(1'b1, 7'h12, 16'h0000, 26);
        chk("R6 long read data", rd_word, 16'hBEEF);
        chk("R6 long read drive phase", oe_in, 16);
        chk("R6 no drive on extra clocks", oe_out, 0);
        four_wire(1'b1, 7'h14, 16'h0000, 24);
        chk("R6 long write register kept", rd_word, init_val(7'h14));
    endtask

    task automatic t_invalid_4w;
        int w0;
        int r0;
        r0 = rd_cnt;
        four_wire(1'b1, 7'h70, 16'h0000, 24);
        chk("R8 unimplemented read zero", rd_word, 16'h0000);
        chk("R8 no read strobe", rd_cnt - r0, 0);
        chk("R9 last word zero read", last_word, 16'h0000);
        w0 = wr_cnt;
        four_wire(1'b0, 7'h71, 16'h3333, 24);
        chk("R8 unimplemented write dropped", wr_cnt - w0, 0);
        chk("R9 last word after write", last_word, 16'h3333);
    endtask

    task automatic t_timeout_4w;
        int w0;
        w0 = wr_cnt;
        cs_n = 1'b0;
        wait_cyc(HALF);
        clock_frame(1'b0, 7'h15, 16'h4444, 24, 1'b0);
        wait_cyc(TMO + 50);
        cs_n = 1'b1;
        wait_cyc(2 * HALF);
        chk("R5 four-wire timeout drops write", wr_cnt - w0, 0);
        four_wire(1'b1, 7'h15, 16'h0000, 24);
        chk("R5 register kept after timeout", rd_word, init_val(7'h15));
    endtask

    task automatic t_three_wire;
        int w0;
        mode_3w = 1'b1;
        cs_n = 1'b1;
        wait_cyc(4);
        w0 = wr_cnt;
        three_wire(1'b0, 7'h05, 16'h1234, 24);
        three_wire(1'b1, 7'h05, 16'h0000, 24);
        chk("R4 three-wire write then read", rd_word, 16'h1234);
        chk("R4 commit at next frame start", wr_cnt - w0, 1);
        chk("R2 three-wire drive phase", oe_in, 16);
        w0 = wr_cnt;
        three_wire(1'b0, 7'h06, 16'h5678, 24);
        wait_cyc(TMO + 50);
        chk("R5 three-wire timeout commits", wr_cnt - w0, 1);
        three_wire(1'b1, 7'h06, 16'h0000, 24);
        chk("R5 three-wire committed data", rd_word, 16'h5678);
    endtask

    initial begin
        wait_cyc(5);
        t_reset;
        rst_n = 1'b1;
        wait_cyc(5);
        t_write_read_4w;
        t_cs_high_4w;
        t_short_4w;
        t_over_4w;
        t_invalid_4w;
        t_timeout_4w;
        t_three_wire;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule